// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Stage

This block is the front of the pipeline for a 32-bit machine with sixteen general registers. Its instructions come in two sizes. A register-register instruction is one halfword: an 8-bit opcode, then two 4-bit register fields. A register-indexed-storage instruction is two halfwords: the same 8-bit opcode and two register fields, then a 4-bit base register field and a 12-bit displacement. The block keeps a program counter that is a byte address aligned to a halfword. It reads one 32-bit word per cycle from an instruction memory whose read data is combinational. It finds the instruction size from the opcode, builds a 32-bit instruction register, and works out the address of the next sequential instruction. The instruction register and the next PC move on together in one interstage register, with a valid bit and a stall from the following stage.

A halfword that is left over in a fetched word is kept in a one-entry buffer. It is used as the first half of the next instruction, so a run of mixed-length instructions usually issues one per cycle. A long instruction can start in the second halfword of a word when that halfword is not buffered. This happens after a redirect to such an address. The controller then spends one cycle in its span state to collect the first half before the second word is read. A redirect from a later stage loads a new PC, empties the buffer and clears the outgoing valid bit.

The controller has two named states. In FETCH it issues an instruction every cycle that it may advance. From there the transition "odd start, long, not buffered" goes to SPAN. SPAN always returns to FETCH through the transition "second word read", which issues the assembled instruction. A redirect forces FETCH from either state.

Top module: `fetch_stage`

## Requirements
- R1: While reset is asserted `out_valid` is 0 and `imem_addr` equals the reset PC (parameter `RESET_PC`, default 0). After reset, fetching starts at that address.
- R2: An opcode (bits 15:8 of an instruction's first halfword) whose two top bits are 00 marks a 2-byte instruction. Every other opcode marks a 4-byte instruction.
- R3: Memory is big-endian. The word at byte address A holds the halfword at A in bits 31:16 and the halfword at A+2 in bits 15:0. A long instruction puts its first halfword in `out_ir[31:16]` and its second in `out_ir[15:0]`. A short instruction puts its halfword in `out_ir[31:16]` and zeros in bits 15:0.
- R4: `out_npc` equals the byte address of the instruction in `out_ir` plus its length. Instructions that are accepted with no redirect between them follow one another in address order.
- R5: While not stalled, an instruction is issued every cycle. This holds for an aligned start, for a short instruction at an odd halfword, and for any instruction whose first halfword is already buffered. The first instruction after such a redirect is valid one clock edge after the redirect edge.
- R6: A long instruction that starts at an odd halfword with no buffered halfword is assembled from two consecutive words. It becomes valid two clock edges after the redirect edge, with exactly one bubble.
- R7: While `out_valid` and `stall` are both 1 and there is no redirect, `out_valid`, `out_ir` and `out_npc` hold their values at the next edge.
- R8: A redirect clears `out_valid` at the next edge, even while stalled. It throws away the buffered halfword, and fetching continues from `redirect_pc`.
- R9: Bit 0 of `redirect_pc` is ignored. The PC is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Next stage cannot take the current instruction |
| redirect | input | 1 | Load a new PC and flush |
| redirect_pc | input | PCW | Byte address of the redirect target |
| imem_addr | output | PCW | Word-aligned byte address to the instruction memory |
| imem_rdata | input | IW | Word read from `imem_addr` in the same cycle |
| out_valid | output | 1 | Interstage register holds an instruction |
| out_ir | output | IW | Instruction register |
| out_npc | output | PCW | Address after the instruction in `out_ir` |

## Verification
The span state is the hardest case to reach. In a straight sequence, every odd-start instruction finds its first halfword already buffered, so the span state is never entered. The stimulus enters it only by redirecting to the second halfword of a word whose opcode marks a long instruction. The bench then counts the edges until the output becomes valid, and compares this with the one-edge latency of aligned and short odd targets. A redirect issued while the output is stalled and valid exercises the rule that a redirect takes priority over the hold.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Controller states of the fetch stage.
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,   // issue one instruction per advancing cycle
        ST_SPAN  = 2'd1    // first half captured, reading the second word
    } fetch_state_e;

    // Width of the opcode-class field that selects the instruction size.
    localparam int unsigned LEN_CLASS_W = 2;

endpackage

// File: rtl/fetch_len_decode.sv
module fetch_len_decode
    import fetch_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic [OPW-1:0] opcode,
    output logic           is_long
);

    // Class 00 in the top bits marks a halfword instruction.
    always_comb begin
        is_long = (opcode[OPW-1 -: LEN_CLASS_W] != '0);
    end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int unsigned     PCW      = 32,
    parameter int unsigned     IW       = 32,
    parameter int unsigned     OPW      = 8,
    parameter logic [PCW-1:0]  RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    input  logic           redirect,
    input  logic [PCW-1:0] redirect_pc,
    output logic [PCW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_rdata,
    output logic           emit,
    output logic [IW-1:0]  emit_ir,
    output logic [PCW-1:0] emit_npc
);

    localparam int unsigned   HW         = IW / 2;
    localparam int unsigned   WB         = $clog2(IW / 8);
    localparam logic [PCW-1:0] HALF_BYTES = PCW'(HW / 8);
    localparam logic [PCW-1:0] FULL_BYTES = PCW'(IW / 8);

    fetch_state_e   state_q, state_d;
    logic [PCW-1:0] pc_q, pc_d;
    logic [HW-1:0]  buf_q, buf_d;
    logic           buf_v_q, buf_v_d;

    logic           odd;
    logic [HW-1:0]  hw_hi, hw_lo, lead_hw;
    logic           lead_long;
    logic [PCW-1:0] word_base;

    // Split the fetched word and pick the halfword that opens the instruction.
    always_comb begin
        odd       = pc_q[WB-1];
        hw_hi     = imem_rdata[IW-1:HW];
        hw_lo     = imem_rdata[HW-1:0];
        lead_hw   = odd ? (buf_v_q ? buf_q : hw_lo) : hw_hi;
        word_base = {pc_q[PCW-1:WB], {WB{1'b0}}};
        imem_addr = (odd && buf_v_q) ? (word_base + FULL_BYTES) : word_base;
    end

    fetch_len_decode #(
        .OPW (OPW)
    ) u_len (
        .opcode  (lead_hw[HW-1 -: OPW]),
        .is_long (lead_long)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (odd && !buf_v_q && lead_long) begin
                    state_d = ST_SPAN;
                end
            end
            ST_SPAN: begin
                state_d = ST_FETCH;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // Output and datapath logic per state.
    always_comb begin
        emit     = 1'b0;
        emit_ir  = '0;
        emit_npc = pc_q;
        buf_d    = buf_q;
        buf_v_d  = buf_v_q;
        unique case (state_q)
            ST_FETCH: begin
                if (!odd) begin
                    emit = 1'b1;
                    if (lead_long) begin
                        emit_ir  = {hw_hi, hw_lo};
                        emit_npc = pc_q + FULL_BYTES;
                        buf_v_d  = 1'b0;
                    end else begin
                        emit_ir  = {hw_hi, {HW{1'b0}}};
                        emit_npc = pc_q + HALF_BYTES;
                        buf_d    = hw_lo;
                        buf_v_d  = 1'b1;
                    end
                end else if (buf_v_q) begin
                    emit = 1'b1;
                    if (lead_long) begin
                        emit_ir  = {buf_q, hw_hi};
                        emit_npc = pc_q + FULL_BYTES;
                        buf_d    = hw_lo;
                        buf_v_d  = 1'b1;
                    end else begin
                        emit_ir  = {buf_q, {HW{1'b0}}};
                        emit_npc = pc_q + HALF_BYTES;
                        buf_v_d  = 1'b0;
                    end
                end else begin
                    if (lead_long) begin
                        buf_d   = hw_lo;
                        buf_v_d = 1'b1;
                    end else begin
                        emit     = 1'b1;
                        emit_ir  = {hw_lo, {HW{1'b0}}};
                        emit_npc = pc_q + HALF_BYTES;
                        buf_v_d  = 1'b0;
                    end
                end
            end
            ST_SPAN: begin
                emit     = 1'b1;
                emit_ir  = {buf_q, hw_hi};
                emit_npc = pc_q + FULL_BYTES;
                buf_d    = hw_lo;
                buf_v_d  = 1'b1;
            end
            default: begin
                buf_v_d = 1'b0;
            end
        endcase
        pc_d = emit ? emit_npc : pc_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else if (redirect) begin
            state_q <= ST_FETCH;
        end else if (advance) begin
            state_q <= state_d;
        end
    end

    // PC and halfword buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            buf_q   <= '0;
            buf_v_q <= 1'b0;
        end else if (redirect) begin
            pc_q    <= {redirect_pc[PCW-1:1], 1'b0};
            buf_v_q <= 1'b0;
        end else if (advance) begin
            pc_q    <= pc_d;
            buf_q   <= buf_d;
            buf_v_q <= buf_v_d;
        end
    end

    AST_SPAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPAN && advance && !redirect) |=> (state_q == ST_FETCH)); // R6

    AST_SPAN_ENTRY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPAN) |-> (odd && buf_v_q)); // R6

    AST_BUF_AT_ODD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        buf_v_q |-> pc_q[WB-1]); // R5

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0); // R9

    AST_REDIRECT_FLUSH_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !buf_v_q); // R8

endmodule

// File: rtl/fetch_outreg.sv
module fetch_outreg #(
    parameter int unsigned PCW = 32,
    parameter int unsigned IW  = 32,
    parameter int unsigned OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           redirect,
    input  logic           emit,
    input  logic [IW-1:0]  emit_ir,
    input  logic [PCW-1:0] emit_npc,
    output logic           advance,
    output logic           out_valid,
    output logic [IW-1:0]  out_ir,
    output logic [PCW-1:0] out_npc
);

    localparam logic [PCW-1:0] HALF_BYTES = PCW'(IW / 16);
    localparam logic [PCW-1:0] FULL_BYTES = PCW'(IW / 8);

    always_comb begin
        advance = !out_valid || !stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ir    <= '0;
            out_npc   <= '0;
        end else if (redirect) begin
            out_valid <= 1'b0;
        end else if (advance) begin
            out_valid <= emit;
            if (emit) begin
                out_ir  <= emit_ir;
                out_npc <= emit_npc;
            end
        end
    end

    // Sequence tracker for the address-order check.
    logic           trk_ok;
    logic [PCW-1:0] trk_npc;
    logic           out_long;

    fetch_len_decode #(
        .OPW (OPW)
    ) u_chk_len (
        .opcode  (out_ir[IW-1 -: OPW]),
        .is_long (out_long)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_ok  <= 1'b0;
            trk_npc <= '0;
        end else if (redirect) begin
            trk_ok  <= 1'b0;
        end else if (out_valid && !stall) begin
            trk_ok  <= 1'b1;
            trk_npc <= out_npc;
        end
    end

    AST_REDIRECT_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !out_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && stall && !redirect) |=>
            (out_valid && $stable(out_ir) && $stable(out_npc))); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && trk_ok) |->
            (out_npc == trk_npc + (out_long ? FULL_BYTES : HALF_BYTES))); // R4

    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_long) |-> (out_ir[IW/2-1:0] == '0)); // R3

    AST_NPC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_npc[0] == 1'b0)); // R9

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage #(
    parameter int unsigned    PCW      = 32,
    parameter int unsigned    IW       = 32,
    parameter int unsigned    OPW      = 8,
    parameter logic [PCW-1:0] RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stall,
    input  logic           redirect,
    input  logic [PCW-1:0] redirect_pc,
    output logic [PCW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_rdata,
    output logic           out_valid,
    output logic [IW-1:0]  out_ir,
    output logic [PCW-1:0] out_npc
);

    logic           advance;
    logic           emit;
    logic [IW-1:0]  emit_ir;
    logic [PCW-1:0] emit_npc;

    fetch_ctrl #(
        .PCW      (PCW),
        .IW       (IW),
        .OPW      (OPW),
        .RESET_PC (RESET_PC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .emit        (emit),
        .emit_ir     (emit_ir),
        .emit_npc    (emit_npc)
    );

    fetch_outreg #(
        .PCW (PCW),
        .IW  (IW),
        .OPW (OPW)
    ) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .redirect  (redirect),
        .emit      (emit),
        .emit_ir   (emit_ir),
        .emit_npc  (emit_npc),
        .advance   (advance),
        .out_valid (out_valid),
        .out_ir    (out_ir),
        .out_npc   (out_npc)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1

endmodule

// File: tb/test_fetch_stage.sv
`timescale 1ns/1ps
module test_fetch_stage;

    localparam int PCW = 32;
    localparam int IW  = 32;
    localparam int NHW = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           stall = 1'b0;
    logic           redirect = 1'b0;
    logic [PCW-1:0] redirect_pc = '0;
    logic [PCW-1:0] imem_addr;
    logic [IW-1:0]  imem_rdata;
    logic           out_valid;
    logic [IW-1:0]  out_ir;
    logic [PCW-1:0] out_npc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] ir;
        logic [31:0] npc;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    // Program image: every third halfword carries a short opcode.
    function automatic logic [15:0] hw_at(input int i);
        int k;
        logic [7:0] op;
        k  = i % NHW;
        op = (k % 3 == 1) ? {2'b00, 6'(k)} : {2'b10, 6'(k)};
        return {op, 8'(k * 11 + 3)};
    endfunction

    assign imem_rdata = {hw_at(2 * int'(imem_addr[7:2])), hw_at(2 * int'(imem_addr[7:2]) + 1)};

    fetch_stage i_fetch_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .out_valid   (out_valid),
        .out_ir      (out_ir),
        .out_npc     (out_npc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: walk the image by the length rule.
    task automatic push_from(input logic [31:0] start, input int n);
        logic [31:0] pc;
        pc = start;
        for (int j = 0; j < n; j++) begin
            exp_t e;
            logic [15:0] h0;
            bit lng;
            h0  = hw_at(int'(pc[7:1]));
            lng = (h0[15:14] != 2'b00);
            e.ir  = lng ? {h0, hw_at(int'(pc[7:1]) + 1)} : {h0, 16'h0000};
            e.npc = pc + (lng ? 32'd4 : 32'd2);
            q.push_back(e);
            pc = e.npc;
        end
    endtask

    task automatic redirect_to(input logic [31:0] target, input logic [31:0] start, input int lat);
        @(negedge clk);
        redirect    = 1'b1;
        redirect_pc = target;
        #2;
        q.delete();
        push_from(start, 200);
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk(!out_valid, "R8 valid cleared", 32'(out_valid), 32'd0);
        if (lat == 2) begin
            @(negedge clk);
            #1;
            chk(!out_valid, "R6 span bubble", 32'(out_valid), 32'd0);
        end
        @(negedge clk);
        #1;
        chk(out_valid, (lat == 2) ? "R6 span issue" : "R5 one-edge issue", 32'(out_valid), 32'd1);
    endtask

    // Monitor side of the scoreboard.
    initial begin
        logic        hold_prev;
        logic [31:0] ir_prev;
        logic [31:0] npc_prev;
        hold_prev = 1'b0;
        ir_prev   = '0;
        npc_prev  = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (hold_prev) begin
                    chk(out_valid, "R7 valid held", 32'(out_valid), 32'd1);
                    chk(out_ir == ir_prev, "R7 ir held", out_ir, ir_prev);
                    chk(out_npc == npc_prev, "R7 npc held", out_npc, npc_prev);
                end
                if (out_valid && !stall) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R4 unexpected issue", out_npc, 32'hffff_ffff);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(out_ir == e.ir, "R3 ir", out_ir, e.ir);
                        chk(out_npc == e.npc, "R2 R4 npc", out_npc, e.npc);
                    end
                end
                hold_prev = out_valid && stall && !redirect;
                ir_prev   = out_ir;
                npc_prev  = out_npc;
            end else begin
                hold_prev = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        push_from(32'd0, 400);
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R1 reset valid", 32'(out_valid), 32'd0);
        chk(imem_addr == 32'd0, "R1 reset addr", imem_addr, 32'd0);
        rst_n = 1'b1;

        // Straight run, no stall.
        repeat (40) @(negedge clk);

        // Irregular stall pattern.
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            stall = lfsr[0] & ~lfsr[3];
            lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        @(negedge clk);
        stall = 1'b0;

        // Odd-start long, not buffered (halfword 3).
        redirect_to(32'd6, 32'd6, 2);
        repeat (20) @(negedge clk);
        // Aligned long start (halfword 0).
        redirect_to(32'd0, 32'd0, 1);
        repeat (10) @(negedge clk);
        // Aligned short start (halfword 4).
        redirect_to(32'd8, 32'd8, 1);
        repeat (10) @(negedge clk);
        // Odd short start (halfword 7).
        redirect_to(32'd14, 32'd14, 1);
        repeat (10) @(negedge clk);
        // Bit 0 of the target is ignored: R9.
        redirect_to(32'd15, 32'd14, 1);
        repeat (10) @(negedge clk);
        // Odd long start near the wrap of the image (halfword 99).
        redirect_to(32'd198, 32'd198, 2);
        repeat (30) @(negedge clk);

        // Redirect while stalled with a valid output: R8 priority.
        @(negedge clk);
        stall = 1'b1;
        repeat (3) @(negedge clk);
        redirect    = 1'b1;
        redirect_pc = 32'd6;
        #2;
        q.delete();
        push_from(32'd6, 200);
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk(!out_valid, "R8 over stall", 32'(out_valid), 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid, "R6 refill under stall", 32'(out_valid), 32'd1);
        @(negedge clk);
        stall = 1'b0;
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule